// File: doc/BRIEF.md
# Inter-Processor Interrupt Pending Unit

This block collects interrupts that one processor sends to another. It keeps a 64-bit pending word for each of two target CPUs, with one bit per sending region. A sender posts an interrupt by storing anything to the target CPU's "post" address. The unit ignores the store data and sets the bit whose index is the requester's region ID, which arrives with the store. The target CPU reads its pending word back through its "acknowledge" address. It retires interrupts by storing a word whose 1-bits name the bits to drop.

One mask word is shared by both CPUs. Each CPU's interrupt line is the registered OR of its pending word ANDed with that mask. The register bus is a single write/read port: a word address, 64-bit write data and a region ID. Read data comes out registered one cycle after the read strobe. Any address accepts stores from any requester.

Top module: `ipi_pend_unit`

## Requirements
- R1: After reset, both pending words, the mask, both `irq` bits and `rdData` are zero.
- R2: A write to address 0 (CPU 0 post) or address 2 (CPU 1 post) sets bit `srcRegion` of that CPU's pending word and leaves every other bit unchanged. Posting a bit that is already set leaves the word unchanged.
- R3: The value of `wrData` has no effect on a post write: only `srcRegion` selects the bit.
- R4: A write to address 1 (CPU 0 acknowledge) or address 3 (CPU 1 acknowledge) clears each pending bit whose `wrData` bit is 1 and keeps the others. All-zero data changes nothing, and all-ones data clears the whole word.
- R5: A read of address 1 or 3 returns that CPU's pending word on `rdData` in the cycle after `rdEn`, as it stood before any write in the same cycle. `rdData` is zero in any cycle that does not follow a read.
- R6: Address 4 holds the shared mask. A write loads `wrData` into it, a read returns it, and it applies to both CPUs.
- R7: `irq[c]` equals the OR of (pending word of CPU c AND mask) as it stood one clock earlier. A write is therefore visible on `irq` after the second rising edge following it.
- R8: Reads of the post addresses (0, 2) and of unused addresses 5 to 7 return zero. Writes to addresses 5 to 7 change no state.
- R9: A post or acknowledge aimed at one CPU never changes the other CPU's pending word or interrupt.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the current cycle |
| rdEn | input | 1 | Read strobe; data follows one cycle later |
| addr | input | 3 | Word address: 0/2 post, 1/3 acknowledge, 4 mask |
| wrData | input | 64 | Write data |
| srcRegion | input | 6 | Region ID of the requester |
| rdData | output | 64 | Registered read data |
| irq | output | 2 | Interrupt line per target CPU, bit 0 = CPU 0 |

## Verification
Posts are issued with all-ones, all-zero and alternating data, so that a design that used the data instead of the region ID shows a wrong word. Region IDs 0, 5, 17 and 63, plus a sweep of all 64, probe both edges of the index range. Acknowledge writes with partial, zero and all-ones data tell clearing by data bit apart from clearing the whole word. The interrupt lines are sampled one edge and two edges after mask and pending changes. This catches both a missing register stage and an extra one, and it also shows whether the mask is truly shared between the two CPUs.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  parameter int IPI_CPUS = 2;
  localparam int CPU_W = (IPI_CPUS > 1) ? $clog2(IPI_CPUS) : 1;

  typedef enum logic [1:0] {
    RK_ZERO = 2'd0,
    RK_PEND = 2'd1,
    RK_MASK = 2'd2
  } rdKind_t;

  // Strobes passed from the decode control to the datapath.
  typedef struct packed {
    logic [IPI_CPUS-1:0] setStb;
    logic [IPI_CPUS-1:0] clrStb;
    logic                maskWr;
    logic                rdEn;
    rdKind_t             rdKind;
    logic [CPU_W-1:0]    rdCpu;
  } ipiStrobes_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ipiStrobes_t       stb
);
  localparam int MASK_ADDR = 2 * IPI_CPUS;

  logic [IPI_CPUS-1:0] setHit;
  logic [IPI_CPUS-1:0] clrHit;

  for (genvar c = 0; c < IPI_CPUS; c++) begin : g_dec
    assign setHit[c] = (addr == ADDR_W'(2 * c));
    assign clrHit[c] = (addr == ADDR_W'(2 * c + 1));
  end

  always_comb begin
    stb        = '0;
    stb.setStb = wrEn ? setHit : '0;
    stb.clrStb = wrEn ? clrHit : '0;
    stb.maskWr = wrEn && (addr == ADDR_W'(MASK_ADDR));
    stb.rdEn   = rdEn;
    stb.rdCpu  = CPU_W'(addr >> 1);
    if (|clrHit) begin
      stb.rdKind = RK_PEND;
    end else if (addr == ADDR_W'(MASK_ADDR)) begin
      stb.rdKind = RK_MASK;
    end else begin
      stb.rdKind = RK_ZERO;
    end
  end
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int REGIONS = 64,
  localparam int ID_W = $clog2(REGIONS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ipiStrobes_t                       stb,
  input  logic [REGIONS-1:0]                wrData,
  input  logic [ID_W-1:0]                   srcRegion,
  output logic [REGIONS-1:0]                rdData,
  output logic [IPI_CPUS-1:0]               irq,
  output logic [IPI_CPUS-1:0][REGIONS-1:0]  pendView,
  output logic [REGIONS-1:0]                maskView
);
  logic [REGIONS-1:0] maskQ;
  logic [REGIONS-1:0] regionBit;
  logic [IPI_CPUS-1:0][REGIONS-1:0] pendQ;

  always_comb begin
    regionBit = '0;
    regionBit[srcRegion] = 1'b1;
  end

  for (genvar c = 0; c < IPI_CPUS; c++) begin : g_cpu
    logic [REGIONS-1:0] setVec;
    logic [REGIONS-1:0] clrVec;
    logic [REGIONS-1:0] pendNext;

    always_comb begin
      setVec   = stb.setStb[c] ? regionBit : '0;
      clrVec   = stb.clrStb[c] ? wrData : '0;
      // Post takes priority over acknowledge so no interrupt is lost.
      pendNext = (pendQ[c] & ~clrVec) | setVec;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ[c] <= '0;
        irq[c]   <= 1'b0;
      end else begin
        pendQ[c] <= pendNext;
        irq[c]   <= |(pendQ[c] & maskQ);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (stb.maskWr) begin
      maskQ <= wrData;
    end
  end

  logic [REGIONS-1:0] rdNext;
  always_comb begin
    unique case (stb.rdKind)
      RK_PEND: rdNext = pendQ[stb.rdCpu];
      RK_MASK: rdNext = maskQ;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      rdData <= stb.rdEn ? rdNext : '0;
    end
  end

  assign pendView = pendQ;
  assign maskView = maskQ;
endmodule

// File: rtl/ipi_pend_unit.sv
module ipi_pend_unit
  import ipi_pkg::*;
#(
  parameter int REGIONS = 64,
  parameter int ADDR_W  = 3,
  localparam int ID_W   = $clog2(REGIONS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REGIONS-1:0]  wrData,
  input  logic [ID_W-1:0]     srcRegion,
  output logic [REGIONS-1:0]  rdData,
  output logic [IPI_CPUS-1:0] irq
);
  ipiStrobes_t stb;
  logic [IPI_CPUS-1:0][REGIONS-1:0] pendView;
  logic [REGIONS-1:0] maskView;

  ipi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .stb  (stb)
  );

  ipi_datapath #(.REGIONS(REGIONS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .srcRegion (srcRegion),
    .rdData    (rdData),
    .irq       (irq),
    .pendView  (pendView),
    .maskView  (maskView)
  );
endmodule

// File: rtl/ipi_pend_unit_chk.sv
module ipi_pend_unit_chk #(
  parameter int REGIONS = 64,
  parameter int ADDR_W  = 3,
  localparam int ID_W   = $clog2(REGIONS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [REGIONS-1:0] wrData,
  input logic [ID_W-1:0]    srcRegion,
  input logic [REGIONS-1:0] rdData,
  input logic [1:0]         irq,
  input logic [REGIONS-1:0] pend0,
  input logic [REGIONS-1:0] pend1,
  input logic [REGIONS-1:0] maskQ
);
  // R2: a post to CPU 0 leaves the requester's bit set
  p_post_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0)) |=> pend0[$past(srcRegion)]);

  // R3: a post changes at most one bit, whatever the data
  p_post_one_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(2)) |=> ($countones(pend1 ^ $past(pend1)) <= 1));

  // R4: acknowledge drops every bit named by the data
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(1)) |=> ((pend0 & $past(wrData)) == '0));

  // R5: no read strobe means zero read data next cycle
  p_rd_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0));

  // R7: interrupt follows masked pending state one edge later
  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq[1] == $past(|(pend1 & maskQ))));

  // R8: reads of the post addresses return zero
  p_post_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == ADDR_W'(0) || addr == ADDR_W'(2))) |=> (rdData == '0));

  // R9: a CPU 0 access leaves CPU 1 untouched
  p_cpu_isolated_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr < ADDR_W'(2)) |=> $stable(pend1));

  // R1: reset clears outputs
  always_comb begin
    if (!rstN) begin
      p_reset_zero_r1: assert (rdData == '0 && irq == 2'b00);
    end
  end
endmodule

bind ipi_pend_unit ipi_pend_unit_chk #(.REGIONS(REGIONS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .wrData    (wrData),
  .srcRegion (srcRegion),
  .rdData    (rdData),
  .irq       (irq),
  .pend0     (pendView[0]),
  .pend1     (pendView[1]),
  .maskQ     (maskView)
);

// File: tb/ipi_pend_unit_bench.sv
module ipi_pend_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [63:0] wrData = '0;
  logic [5:0]  srcRegion = '0;
  logic [63:0] rdData;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;

  logic [63:0] modelPend [2];
  logic [63:0] modelMask;
  logic [63:0] expQ [$];
  string       tagQ [$];

  ipi_pend_unit u_ipi_pend_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .srcRegion(srcRegion), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Driver: one write, model updated from the requirements.
  task automatic busWrite(logic [2:0] a, logic [63:0] d, logic [5:0] r);
    wrEn = 1'b1; addr = a; wrData = d; srcRegion = r;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      3'd0: modelPend[0][r] = 1'b1;
      3'd2: modelPend[1][r] = 1'b1;
      3'd1: modelPend[0] = modelPend[0] & ~d;
      3'd3: modelPend[1] = modelPend[1] & ~d;
      3'd4: modelMask = d;
      default: ;
    endcase
  endtask

  // Driver: one read, expected value queued for the monitor.
  task automatic busRead(logic [2:0] a, string tag);
    logic [63:0] e;
    case (a)
      3'd1: e = modelPend[0];
      3'd3: e = modelPend[1];
      3'd4: e = modelMask;
      default: e = '0;
    endcase
    expQ.push_back(e);
    tagQ.push_back(tag);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Monitor: compares registered read data after each read edge.
  always @(posedge clk) begin
    if (rdEn && rstN) begin
      #2;
      if (expQ.size() > 0) begin
        check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkIrq(string tag);
    check(tag, {62'd0, irq},
          {62'd0, |(modelPend[1] & modelMask), |(modelPend[0] & modelMask)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog got=hang exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    modelPend[0] = '0; modelPend[1] = '0; modelMask = '0;
    idle(3);
    check("R1 irq after reset", {62'd0, irq}, 64'd0);
    check("R1 rdData after reset", rdData, 64'd0);
    rstN = 1'b1;
    idle(1);
    busRead(3'd1, "R1 pend0 reset");
    busRead(3'd3, "R1 pend1 reset");
    busRead(3'd4, "R1 mask reset");

    // Posts with varied data: data must not matter.
    busWrite(3'd0, '1, 6'd5);
    busRead(3'd1, "R2 R3 post region 5 all-ones data");
    busWrite(3'd0, '0, 6'd63);
    busWrite(3'd0, 64'hAAAA_5555_AAAA_5555, 6'd0);
    busRead(3'd1, "R2 R3 post regions 0 and 63");
    busWrite(3'd0, '0, 6'd5);
    busRead(3'd1, "R2 repeat post unchanged");
    busWrite(3'd2, '1, 6'd17);
    busRead(3'd3, "R2 R9 post cpu1 region 17");
    busRead(3'd1, "R9 cpu0 unchanged by cpu1 post");

    // Read returns state before same-cycle write.
    expQ.push_back(modelPend[0]);
    tagQ.push_back("R5 read before same-cycle ack");
    rdEn = 1'b1; wrEn = 1'b1; addr = 3'd1; wrData = 64'h1;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    modelPend[0] = modelPend[0] & ~64'h1;
    idle(1);
    check("R5 rdData zero without read", rdData, 64'd0);
    busRead(3'd1, "R4 ack bit 0 took effect");

    // Interrupt with shared mask.
    idle(2);
    checkIrq("R7 irq low with zero mask");
    wrEn = 1'b1; addr = 3'd4; wrData = 64'h20; srcRegion = '0;
    @(negedge clk);
    wrEn = 1'b0;
    check("R7 irq not yet after one edge", {62'd0, irq}, 64'd0);
    modelMask = 64'h20;
    @(negedge clk);
    checkIrq("R6 R7 irq0 after two edges");
    busRead(3'd4, "R6 mask readback");
    busWrite(3'd4, 64'h20 | (64'h1 << 17), '0);
    idle(1);
    checkIrq("R6 shared mask raises irq1");

    // Acknowledge patterns.
    busWrite(3'd1, 64'd0, '0);
    busRead(3'd1, "R4 ack zero data no change");
    busWrite(3'd1, 64'h20, '0);
    busRead(3'd1, "R4 ack bit 5 keeps bit 63");
    checkIrq("R4 R7 irq0 drops after ack");
    checkIrq("R9 irq1 stays");

    // Unused addresses and post-address reads.
    busRead(3'd0, "R8 read post addr 0");
    busRead(3'd2, "R8 read post addr 2");
    busRead(3'd5, "R8 read addr 5");
    busWrite(3'd6, '1, 6'd9);
    busWrite(3'd7, '1, 6'd3);
    busRead(3'd4, "R8 mask unchanged after unused write");
    busRead(3'd1, "R8 pend0 unchanged after unused write");
    busRead(3'd3, "R8 pend1 unchanged after unused write");

    // Sweep every region into cpu1, then clear all.
    for (int r = 0; r < 64; r++) busWrite(3'd2, 64'(r), 6'(r));
    busRead(3'd3, "R2 all regions posted");
    busWrite(3'd3, '1, '0);
    busRead(3'd3, "R4 all-ones ack clears word");
    idle(1);
    checkIrq("R7 irq1 low after full clear");
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule